// File: doc/BRIEF.md
# ADC Sequence Status and Result-Pointer Unit

This block holds the digital status for a converter sequencer that fills eight result registers. A stubbed converter delivers each finished conversion as a stream beat on `conv_valid`/`conv_data`. The unit stores the beat in the result register chosen by a 3-bit conversion pointer and raises that register's conversion-complete flag. It counts conversions against the programmed sequence length and raises a sequence-complete flag at the end of each sequence.

Two overrun conditions are tracked. A trigger overrun is flagged when a trigger edge arrives while a sequence is still running. A result overrun is flagged when a result register is overwritten before its flag was cleared. A simple register bus can start a sequence, abort one, clear flags by writing ones, and read the results and the packed status byte. A sequence can also be started by an external trigger edge when edge-trigger mode is enabled.

The stream input has back-pressure. `conv_ready` is high only while a sequence is running and no control write (start or abort) is present in the same cycle. A beat transfers on a cycle where both `conv_valid` and `conv_ready` are high, and the converter holds the beat until it transfers. Control and status pins are plain levels or single-cycle strobes.

Top module: `adc_seq_status`

## Requirements
- R1: After reset, `status`, `ccf` and `seq_busy` are all zero.
- R2: An accepted beat is stored in result register N, where N is the conversion pointer (`status[2:0]`) in that cycle. The beat sets `ccf[N]`, and the pointer then advances by one, wrapping from 7 to 0. Reading bus address 8+N returns the stored value on `rd_data` in the same cycle.
- R3: The accepted beat that brings the count of conversions in the sequence up to `seq_len` (1 to 8) sets the sequence-complete flag, `status[7]`. With `scan_mode` high, the unit stays busy and the next sequence begins. With `scan_mode` low, `seq_busy` falls.
- R4: The sequence-complete flag is cleared by a bus write to the status address (4) with data bit 7 set, by a write to the start address (0), or by a read of a result address (8 to 15) while `fast_clr` is high. When a set and a clear hit in the same cycle, the set wins.
- R5: With `edge_trig_mode` high, a `trig_edge` pulse while `seq_busy` is high sets the trigger-overrun flag, `status[5]`.
- R6: The trigger-overrun flag is cleared by a write to address 4 with data bit 5 set, by a write to any abort address (1, 2, 3), or by a write to address 0. A set in the same cycle wins.
- R7: An accepted beat whose target register already has its `ccf` bit set raises the result-overrun flag, `status[4]`. That flag is cleared by a write to address 4 with data bit 4 set, or by the start of a new sequence (an address-0 write or a trigger start).
- R8: With `fifo_mode` low, the pointer is zero at the start of every sequence and returns to zero after the last conversion of a sequence.
- R9: With `fifo_mode` high, a trigger-started sequence keeps the pointer where it was. A write to address 0 or to addresses 1 to 3 always forces the pointer to zero.
- R10: `status[6]` and `status[3]` always read 0. Status writes never change `status[2:0]`. Reading address 4 returns the status byte and reading address 5 returns `ccf`.
- R11: `ccf[N]` is cleared by a read of address 8+N, by a write to address 5 with data bit N set, or by a new sequence start. A set in the same cycle wins.
- R12: `conv_ready` equals `seq_busy` and no write to addresses 0 to 3 in the current cycle. A write to address 0 makes the unit busy. A write to addresses 1 to 3 stops the unit.
- R13: With `edge_trig_mode` high and the unit idle, a `trig_edge` pulse starts a sequence. With `edge_trig_mode` low, `trig_edge` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_len | input | 4 | Conversions per sequence, 1 to 8 |
| scan_mode | input | 1 | Restart a sequence automatically after each one completes |
| fifo_mode | input | 1 | Keep the pointer running across sequences |
| edge_trig_mode | input | 1 | Enable trigger edges to start a sequence and to raise overruns |
| trig_edge | input | 1 | Single-cycle pulse for a detected active trigger edge |
| fast_clr | input | 1 | Result reads also clear sequence-complete |
| conv_valid | input | 1 | Converter result beat is valid |
| conv_ready | output | 1 | Unit can accept a beat |
| conv_data | input | 10 | Conversion result |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (its side effects are the flag clears) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| rd_data | output | 10 | Read data for `bus_addr` |
| status | output | 8 | Packed status byte |
| ccf | output | 8 | Conversion-complete flag for each result register |
| seq_busy | output | 1 | A sequence is in progress |

## Verification
The assertions run on every cycle. They cover the reserved status bits, the handshake gating, and the setting of `ccf` for the register being written. They also check that control writes zero the pointer, that the overrun flags follow their triggering events, and that status writes leave the pointer alone.

Some behaviour only the bench scenarios can show. This covers where a sequence ends for a given `seq_len`, and pointer continuity across trigger-started FIFO sequences versus its return to zero in non-FIFO mode. It also covers result-overrun under scan mode and set-over-clear collisions. The fast-clear read path and result read-back values are likewise checked only by the bench, which compares every output against a cycle model.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;
  // register bus address map
  localparam int unsigned ADR_START = 0;
  localparam int unsigned ADR_ABT_LO = 1;
  localparam int unsigned ADR_ABT_HI = 3;
  localparam int unsigned ADR_STAT = 4;
  localparam int unsigned ADR_CCF = 5;
  localparam int unsigned ADR_RES = 8;
  // status byte field positions
  localparam int unsigned BIT_SEQ = 7;
  localparam int unsigned BIT_TOV = 5;
  localparam int unsigned BIT_ROV = 4;
  localparam int unsigned REG_W = 8;

  function automatic logic [REG_W-1:0] pack_status(input logic seq_done,
                                                   input logic trig_ovr,
                                                   input logic res_ovr,
                                                   input logic [2:0] ptr);
    logic [REG_W-1:0] b;
    b = '0;
    b[BIT_SEQ] = seq_done;
    b[BIT_TOV] = trig_ovr;
    b[BIT_ROV] = res_ovr;
    b[2:0] = ptr;
    return b;
  endfunction
endpackage

// File: rtl/adc_sticky_flag.sv
module adc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // hardware set has priority over any clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= set_i | (flag_o & ~clr_i);
  end
endmodule

// File: rtl/adc_bus_decode.sv
module adc_bus_decode
  import adc_stat_pkg::*;
#(
  parameter int unsigned NUM_RES = 8,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  input  logic                fast_clr,
  input  logic                edge_trig_mode,
  input  logic                trig_edge,
  input  logic                busy,
  output logic                start_wr,
  output logic                abort_wr,
  output logic                seq_w1c,
  output logic                tov_w1c,
  output logic                rov_w1c,
  output logic                res_rd_fast,
  output logic                trig_start,
  output logic                trig_ovr,
  output logic [NUM_RES-1:0]  ccf_w1c,
  output logic [NUM_RES-1:0]  res_rd
);
  logic stat_wr, ccf_wr;

  assign start_wr = bus_wr && (bus_addr == ADDR_W'(ADR_START));
  assign abort_wr = bus_wr && (bus_addr >= ADDR_W'(ADR_ABT_LO))
                           && (bus_addr <= ADDR_W'(ADR_ABT_HI));
  assign stat_wr  = bus_wr && (bus_addr == ADDR_W'(ADR_STAT));
  assign ccf_wr   = bus_wr && (bus_addr == ADDR_W'(ADR_CCF));

  assign seq_w1c  = stat_wr && bus_wdata[BIT_SEQ];
  assign tov_w1c  = stat_wr && bus_wdata[BIT_TOV];
  assign rov_w1c  = stat_wr && bus_wdata[BIT_ROV];

  // a trigger edge only counts in edge mode; control writes take precedence
  assign trig_start = edge_trig_mode && trig_edge && !busy && !start_wr && !abort_wr;
  assign trig_ovr   = edge_trig_mode && trig_edge && busy;

  for (genvar i = 0; i < NUM_RES; i++) begin : g_res
    assign res_rd[i]  = bus_rd && (bus_addr == ADDR_W'(ADR_RES + i));
    if (i < REG_W) begin : g_w1c
      assign ccf_w1c[i] = ccf_wr && bus_wdata[i];
    end else begin : g_now1c
      assign ccf_w1c[i] = 1'b0;
    end
  end

  assign res_rd_fast = fast_clr && (|res_rd);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int unsigned NUM_RES = 8,
  localparam int unsigned PTR_W = $clog2(NUM_RES),
  localparam int unsigned LEN_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] seq_len,
  input  logic             scan_mode,
  input  logic             fifo_mode,
  input  logic             start_wr,
  input  logic             abort_wr,
  input  logic             trig_start,
  input  logic             conv_valid,
  output logic             conv_ready,
  output logic             accept,
  output logic             last,
  output logic             busy,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] cnt;
  logic [PTR_W-1:0] ptr_inc;
  logic             ctrl_wr;

  assign ctrl_wr    = start_wr | abort_wr;
  assign conv_ready = busy & ~ctrl_wr;
  assign accept     = conv_valid & conv_ready;
  assign last       = ({1'b0, cnt} + LEN_W'(1)) >= seq_len;
  assign ptr_inc    = (ptr == PTR_W'(NUM_RES - 1)) ? '0 : ptr + PTR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      ptr  <= '0;
    end else if (ctrl_wr) begin
      // start or abort from the bus: pointer cleared regardless of mode
      busy <= start_wr;
      cnt  <= '0;
      ptr  <= '0;
    end else if (trig_start) begin
      busy <= 1'b1;
      cnt  <= '0;
      if (!fifo_mode) ptr <= '0;
    end else if (accept) begin
      if (last) begin
        cnt <= '0;
        if (!scan_mode) busy <= 1'b0;
        ptr <= fifo_mode ? ptr_inc : '0;
      end else begin
        cnt <= cnt + PTR_W'(1);
        ptr <= ptr_inc;
      end
    end
  end
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store
  import adc_stat_pkg::*;
#(
  parameter int unsigned NUM_RES = 8,
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned PTR_W = $clog2(NUM_RES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PTR_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [REG_W-1:0]   stat_byte,
  input  logic [NUM_RES-1:0] ccf_vec,
  output logic [DATA_W-1:0]  rd_data
);
  logic [DATA_W-1:0] res_q [NUM_RES];

  for (genvar i = 0; i < NUM_RES; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               res_q[i] <= '0;
      else if (wr_en && wr_idx == PTR_W'(i))    res_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADR_STAT)) rd_data = DATA_W'(stat_byte);
    if (rd_addr == ADDR_W'(ADR_CCF))  rd_data = DATA_W'(ccf_vec);
    for (int i = 0; i < NUM_RES; i++) begin
      if (rd_addr == ADDR_W'(ADR_RES + i)) rd_data = res_q[i];
    end
  end
endmodule

// File: rtl/adc_seq_status.sv
module adc_seq_status
  import adc_stat_pkg::*;
#(
  parameter int unsigned NUM_RES = 8,
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned PTR_W = $clog2(NUM_RES),
  localparam int unsigned LEN_W = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEN_W-1:0]   seq_len,
  input  logic               scan_mode,
  input  logic               fifo_mode,
  input  logic               edge_trig_mode,
  input  logic               trig_edge,
  input  logic               fast_clr,
  input  logic               conv_valid,
  output logic               conv_ready,
  input  logic [DATA_W-1:0]  conv_data,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]  rd_data,
  output logic [REG_W-1:0]   status,
  output logic [NUM_RES-1:0] ccf,
  output logic               seq_busy
);
  logic start_wr, abort_wr, seq_w1c, tov_w1c, rov_w1c, res_rd_fast;
  logic trig_start, trig_ovr, accept, last;
  logic seq_done, tov_flag, rov_flag, new_seq;
  logic [NUM_RES-1:0] ccf_w1c, res_rd;
  logic [PTR_W-1:0]   ptr;

  adc_bus_decode #(.NUM_RES(NUM_RES), .ADDR_W(ADDR_W)) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .fast_clr(fast_clr), .edge_trig_mode(edge_trig_mode), .trig_edge(trig_edge),
    .busy(seq_busy), .start_wr(start_wr), .abort_wr(abort_wr),
    .seq_w1c(seq_w1c), .tov_w1c(tov_w1c), .rov_w1c(rov_w1c),
    .res_rd_fast(res_rd_fast), .trig_start(trig_start), .trig_ovr(trig_ovr),
    .ccf_w1c(ccf_w1c), .res_rd(res_rd)
  );

  adc_seq_ctrl #(.NUM_RES(NUM_RES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .seq_len(seq_len), .scan_mode(scan_mode),
    .fifo_mode(fifo_mode), .start_wr(start_wr), .abort_wr(abort_wr),
    .trig_start(trig_start), .conv_valid(conv_valid), .conv_ready(conv_ready),
    .accept(accept), .last(last), .busy(seq_busy), .ptr(ptr)
  );

  assign new_seq = start_wr | trig_start;

  adc_sticky_flag u_seq_flag (
    .clk(clk), .rst_n(rst_n), .set_i(accept & last),
    .clr_i(seq_w1c | start_wr | res_rd_fast), .flag_o(seq_done)
  );

  adc_sticky_flag u_tov_flag (
    .clk(clk), .rst_n(rst_n), .set_i(trig_ovr),
    .clr_i(tov_w1c | start_wr | abort_wr), .flag_o(tov_flag)
  );

  adc_sticky_flag u_rov_flag (
    .clk(clk), .rst_n(rst_n), .set_i(accept & ccf[ptr]),
    .clr_i(rov_w1c | new_seq), .flag_o(rov_flag)
  );

  for (genvar i = 0; i < NUM_RES; i++) begin : g_ccf
    adc_sticky_flag u_ccf (
      .clk(clk), .rst_n(rst_n), .set_i(accept && ptr == PTR_W'(i)),
      .clr_i(res_rd[i] | ccf_w1c[i] | new_seq), .flag_o(ccf[i])
    );
  end

  assign status = pack_status(seq_done, tov_flag, rov_flag, 3'(ptr));

  adc_result_store #(.NUM_RES(NUM_RES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_idx(ptr), .wr_data(conv_data),
    .rd_addr(bus_addr), .stat_byte(status), .ccf_vec(ccf), .rd_data(rd_data)
  );
endmodule

// File: rtl/adc_seq_status_chk.sv
module adc_seq_status_chk #(
  parameter int unsigned NUM_RES = 8,
  parameter int unsigned ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               edge_trig_mode,
  input logic               trig_edge,
  input logic               conv_valid,
  input logic               conv_ready,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [7:0]         status,
  input logic [NUM_RES-1:0] ccf,
  input logic               seq_busy
);
  logic ctrl_w, abt_w, stat_w, acc;
  assign ctrl_w = bus_wr && bus_addr <= ADDR_W'(3);
  assign abt_w  = bus_wr && bus_addr >= ADDR_W'(1) && bus_addr <= ADDR_W'(3);
  assign stat_w = bus_wr && bus_addr == ADDR_W'(4);
  assign acc    = conv_valid && conv_ready;

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] == 1'b0 && status[3] == 1'b0);

  // R12
  ready_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_ready |-> (seq_busy && !ctrl_w));

  // R2
  ccf_set_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ccf[$past(status[2:0])]);

  // R9
  ptr_cleared_by_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w |=> status[2:0] == 3'd0);

  // R5
  trig_overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_trig_mode && trig_edge && seq_busy) |=> status[5]);

  // R6
  trig_overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_w && !(edge_trig_mode && trig_edge && seq_busy)) |=> !status[5]);

  // R7
  result_overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ccf[status[2:0]]) |=> status[4]);

  // R4
  seq_flag_start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0)) |=> !status[7]);

  // R10
  ptr_kept_on_stat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w && !acc && !trig_edge) |=> $stable(status[2:0]));
endmodule

bind adc_seq_status adc_seq_status_chk #(.NUM_RES(NUM_RES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_trig_mode(edge_trig_mode), .trig_edge(trig_edge),
  .conv_valid(conv_valid), .conv_ready(conv_ready), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .status(status), .ccf(ccf), .seq_busy(seq_busy)
);

// File: tb/test_adc_seq_status.sv
module test_adc_seq_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] seq_len = 4'd1;
  logic       scan_mode = 0, fifo_mode = 0, edge_trig_mode = 0, trig_edge = 0, fast_clr = 0;
  logic       conv_valid = 0;
  logic [9:0] conv_data = '0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       conv_ready, seq_busy;
  logic [9:0] rd_data;
  logic [7:0] status, ccf;

  int checks = 0, failures = 0;
  bit done = 0;

  // cycle model state
  logic       m_busy, m_scf, m_tov, m_rov;
  logic [2:0] m_ptr, m_cnt;
  logic [7:0] m_ccf;
  logic [9:0] m_res [8];

  always #10 clk = ~clk;

  adc_seq_status i_adc_seq_status (
    .clk(clk), .rst_n(rst_n), .seq_len(seq_len), .scan_mode(scan_mode),
    .fifo_mode(fifo_mode), .edge_trig_mode(edge_trig_mode), .trig_edge(trig_edge),
    .fast_clr(fast_clr), .conv_valid(conv_valid), .conv_ready(conv_ready),
    .conv_data(conv_data), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .status(status), .ccf(ccf),
    .seq_busy(seq_busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_status();
    return {m_scf, 1'b0, m_tov, m_rov, 1'b0, m_ptr};
  endfunction

  function automatic logic [9:0] m_read(input logic [3:0] a);
    if (a == 4'd4) return {2'b0, m_status()};
    if (a == 4'd5) return {2'b0, m_ccf};
    if (a >= 4'd8) return m_res[a - 4'd8];
    return '0;
  endfunction

  function automatic void m_reset();
    m_busy = 0; m_scf = 0; m_tov = 0; m_rov = 0; m_ptr = 0; m_cnt = 0; m_ccf = 0;
    for (int i = 0; i < 8; i++) m_res[i] = '0;
  endfunction

  // next state from the requirements, using the inputs present this cycle
  function automatic void m_advance();
    logic st, ab, ctl, ts, acc, lst, nseq, rdr;
    logic [7:0] nccf;
    st   = bus_wr && bus_addr == 4'd0;
    ab   = bus_wr && bus_addr >= 4'd1 && bus_addr <= 4'd3;
    ctl  = st || ab;
    ts   = edge_trig_mode && trig_edge && !m_busy && !ctl;
    acc  = conv_valid && m_busy && !ctl;
    lst  = ({1'b0, m_cnt} + 4'd1) >= seq_len;
    nseq = st || ts;
    rdr  = bus_rd && bus_addr >= 4'd8;
    nccf = m_ccf;
    for (int i = 0; i < 8; i++) begin
      if ((bus_rd && bus_addr == 4'(8 + i)) || (bus_wr && bus_addr == 4'd5 && bus_wdata[i]) || nseq)
        nccf[i] = 1'b0;
      if (acc && m_ptr == 3'(i)) nccf[i] = 1'b1;
    end
    // flags
    if ((bus_wr && bus_addr == 4'd4 && bus_wdata[7]) || st || (rdr && fast_clr)) m_scf = 0;
    if (acc && lst) m_scf = 1;
    if (bus_wr && bus_addr == 4'd4 && bus_wdata[5] || ctl) m_tov = 0;
    if (edge_trig_mode && trig_edge && m_busy) m_tov = 1;
    if (acc && m_ccf[m_ptr]) m_rov = 1;
    else if ((bus_wr && bus_addr == 4'd4 && bus_wdata[4]) || nseq) m_rov = 0;
    if (acc) m_res[m_ptr] = conv_data;
    m_ccf = nccf;
    // sequencing
    if (ctl) begin
      m_busy = st; m_cnt = 0; m_ptr = 0;
    end else if (ts) begin
      m_busy = 1; m_cnt = 0;
      if (!fifo_mode) m_ptr = 0;
    end else if (acc) begin
      if (lst) begin
        m_cnt = 0;
        if (!scan_mode) m_busy = 0;
        m_ptr = fifo_mode ? m_ptr + 3'd1 : 3'd0;
      end else begin
        m_cnt = m_cnt + 3'd1;
        m_ptr = m_ptr + 3'd1;
      end
    end
  endfunction

  task automatic idle_inputs();
    bus_wr = 0; bus_rd = 0; trig_edge = 0; conv_valid = 0;
  endtask

  // inputs have been set right after a falling edge; run one clock
  task automatic step();
    logic ctl;
    #1;
    ctl = bus_wr && bus_addr <= 4'd3;
    chk(conv_ready === (m_busy && !ctl), "R12 conv_ready", conv_ready, m_busy && !ctl);
    chk(rd_data === m_read(bus_addr), "R2 rd_data", rd_data, m_read(bus_addr));
    m_advance();
    @(negedge clk);
    chk(status[7] === m_scf, "R3 R4 sequence flag", status[7], m_scf);
    chk(status[5] === m_tov, "R5 R6 trigger overrun", status[5], m_tov);
    chk(status[4] === m_rov, "R7 result overrun", status[4], m_rov);
    chk(status[2:0] === m_ptr, "R8 R9 pointer", status[2:0], m_ptr);
    chk(status[6] === 1'b0 && status[3] === 1'b0, "R10 reserved bits", status, m_status());
    chk(ccf === m_ccf, "R11 ccf", ccf, m_ccf);
    chk(seq_busy === m_busy, "R12 busy", seq_busy, m_busy);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    idle_inputs(); bus_wr = 1; bus_addr = a; bus_wdata = d; step(); idle_inputs();
  endtask

  task automatic feed(input int n);
    for (int k = 0; k < n; k++) begin
      idle_inputs(); conv_valid = 1; conv_data = 10'($urandom); step();
    end
    idle_inputs();
  endtask

  task automatic pulse_trig();
    idle_inputs(); trig_edge = 1; step(); idle_inputs();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(status === 8'h00, "R1 status after reset", status, 0);
    chk(ccf === 8'h00, "R1 ccf after reset", ccf, 0);
    chk(seq_busy === 1'b0, "R1 busy after reset", seq_busy, 0);

    // R8 non-FIFO three-conversion sequence
    seq_len = 4'd3; fifo_mode = 0; scan_mode = 0;
    wr(4'd0, 8'h00);
    feed(3);
    chk(status[2:0] === 3'd0, "R8 pointer back to zero", status[2:0], 0);
    chk(status[7] === 1'b1, "R3 sequence flag set", status[7], 1);
    chk(seq_busy === 1'b0, "R3 idle after sequence", seq_busy, 0);
    chk(ccf === 8'h07, "R2 flags for three results", ccf, 8'h07);

    // R4 fast clear read of result 0, also clears ccf[0] (R11)
    fast_clr = 1; idle_inputs(); bus_rd = 1; bus_addr = 4'd8; step(); idle_inputs(); fast_clr = 0;
    chk(status[7] === 1'b0, "R4 fast clear read", status[7], 0);
    chk(ccf[0] === 1'b0, "R11 read clears ccf", ccf[0], 0);

    // R13 trigger ignored in level mode
    edge_trig_mode = 0; pulse_trig();
    chk(seq_busy === 1'b0, "R13 trigger ignored", seq_busy, 0);

    // R9 FIFO continuity over two trigger-started sequences of 5
    fifo_mode = 1; edge_trig_mode = 1; seq_len = 4'd5;
    wr(4'd1, 8'h00);
    pulse_trig(); feed(5);
    pulse_trig(); feed(5);
    chk(status[2:0] === 3'd2, "R9 pointer wrapped", status[2:0], 2);
    wr(4'd2, 8'h00);
    chk(status[2:0] === 3'd0, "R9 abort clears pointer", status[2:0], 0);

    // R5 trigger overrun during a sequence
    pulse_trig(); pulse_trig();
    chk(status[5] === 1'b1, "R5 trigger overrun", status[5], 1);
    wr(4'd3, 8'h00);
    chk(status[5] === 1'b0, "R6 abort clears overrun", status[5], 0);

    // R7 scan mode overrun on ninth beat
    fifo_mode = 0; scan_mode = 1; seq_len = 4'd8;
    wr(4'd0, 8'h00); feed(9);
    chk(status[4] === 1'b1, "R7 result overrun", status[4], 1);
    chk(seq_busy === 1'b1, "R3 scan keeps busy", seq_busy, 1);

    // R10 status write does not move pointer
    wr(4'd4, 8'hFF);
    chk(status[2:0] === 3'd1, "R10 pointer unchanged", status[2:0], 1);

    // R4 set wins over write-one clear on the last beat
    scan_mode = 0; seq_len = 4'd1;
    wr(4'd0, 8'h00);
    idle_inputs(); conv_valid = 1; bus_wr = 1; bus_addr = 4'd4; bus_wdata = 8'h80; step(); idle_inputs();
    chk(status[7] === 1'b1, "R4 set wins", status[7], 1);

    // random mix
    for (int c = 0; c < 4000; c++) begin
      int r;
      if (c % 200 == 0) begin
        fifo_mode = 1'($urandom); scan_mode = 1'($urandom);
        edge_trig_mode = 1'($urandom); fast_clr = 1'($urandom);
        seq_len = 4'(1 + $urandom % 8);
      end
      idle_inputs();
      conv_valid = ($urandom % 2) == 0;
      conv_data = 10'($urandom);
      trig_edge = ($urandom % 20) == 0;
      r = $urandom % 100;
      if (r < 3)       begin bus_wr = 1; bus_addr = 4'd0; end
      else if (r < 5)  begin bus_wr = 1; bus_addr = 4'(1 + $urandom % 3); end
      else if (r < 11) begin bus_wr = 1; bus_addr = 4'd4; end
      else if (r < 16) begin bus_wr = 1; bus_addr = 4'd5; end
      bus_wdata = 8'($urandom);
      if ($urandom % 5 == 0) begin
        bus_rd = 1;
        bus_addr = bus_wr ? bus_addr : 4'($urandom);
      end
      step();
    end
    idle_inputs();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule